// File: doc/BRIEF.md
# Serial Control Word Receiver with Latch

This block is the device-side control port of an RF attenuator or RF switch. A host sends a control word over a four-wire serial link. The link has a serial clock, a data line into the device, an active-low chip-select for this device and a data line back to the host. The word enters a shift register one bit at a time. The analog control bits come from a second register, which is separate from the shift register. That second register loads only when a latch-enable pulse arrives. When it loads, it takes the complete word in one system clock cycle. A partial shift therefore never reaches the analog hardware. A step code also never passes through an unintended intermediate value, for example 31 between 15 and 16.

All four link inputs are brought into the system clock domain through two-flop synchronisers. Serial clock edges are detected in that domain. A bit counter records how many bits were shifted during the current chip-select window. A latch-enable is applied only when exactly one word length of bits has arrived. Any other latch-enable is dropped, and it sets a sticky length-error flag. During each transaction the device sends the word that is currently applied back to the host, most significant bit first. This lets the host read back the last value it applied. The link has no back-pressure. The host must pace the serial clock slowly enough for the synchronisers: each level must be held for at least three system clock cycles.

Top module: `ctlword_rx`

## Requirements
- R1: After reset, `word_o` equals the parameter `SAFE_WORD` (default all ones), `len_err_o` is 0 and `miso_o` equals bit `WORD_W-1` of `SAFE_WORD`.
- R2: Bits are sampled on rising edges of `sclk_i` while `cs_n_i` is low, most significant bit first. After a latch, the first bit shifted sits at bit `WORD_W-1` of `word_o` and the last bit shifted sits at bit 0.
- R3: `word_o` does not change while bits are being shifted in. It changes only after a rising edge on `le_i`.
- R4: An accepted latch changes every bit of `word_o` in the same cycle. No value other than the old word or the new word ever appears on `word_o`.
- R5: Edges on `sclk_i` while `cs_n_i` is high have no effect on the shifted word.
- R6: A rising edge on `le_i` after fewer than `WORD_W` shifted bits leaves `word_o` unchanged and sets `len_err_o`.
- R7: A rising edge on `le_i` after more than `WORD_W` shifted bits leaves `word_o` unchanged and sets `len_err_o`.
- R8: `len_err_o` stays set until reset, including across later accepted latches.
- R9: During a transaction, `miso_o` presents the value of `word_o` captured when `cs_n_i` fell, most significant bit first. It advances one bit on each falling edge of `sclk_i`.
- R10: The bit count restarts at zero each time `cs_n_i` falls. An aborted partial transaction therefore does not affect the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| mosi_i | input | 1 | Serial data from the host |
| cs_n_i | input | 1 | Active-low chip-select for this device |
| le_i | input | 1 | Latch-enable; a rising edge requests the transfer |
| word_o | output | WORD_W | Applied parallel control word |
| miso_o | output | 1 | Serial read-back of the applied word |
| len_err_o | output | 1 | Sticky flag for a rejected latch because of a wrong bit count |

## Verification
The bench writes directed words and random words of exactly the word length, and checks both the latched value and the read-back of the previous value. Together these separate correct bit order and correct latching from the failure modes: reversed order, a shifted-off bit, or a stale read-back. The pair 15 then 16 is watched on every cycle, so any intermediate code such as 31 would be seen. Writes one bit short and one bit long separate an exact length check from a loose one. Serial clock toggles while the chip-select is high separate a gated shift register from an ungated one. An aborted partial write followed by a full write shows whether the counter restarts. A rejected write followed by a valid one shows whether the error flag is sticky.

// File: rtl/ctlword_rx_pkg.sv
package ctlword_rx_pkg;

  // Serial link signals, grouped so the synchroniser handles them as one vector.
  typedef struct packed {
    logic sclk;
    logic mosi;
    logic cs_n;
    logic le;
  } link_t;

  // Idle levels of the link: clock low, data low, chip-select released, latch low.
  localparam link_t LINK_IDLE = '{sclk: 1'b0, mosi: 1'b0, cs_n: 1'b1, le: 1'b0};

  // The counter must reach WORD_W+1, the value that marks "too many bits".
  function automatic int unsigned cnt_width(input int unsigned w);
    return $clog2(w + 2);
  endfunction

endpackage

// File: rtl/ctlword_sync.sv
module ctlword_sync #(
  parameter int unsigned    N       = 4,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [N-1:0] meta;

  generate
    for (genvar g = 0; g < N; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta[g] <= RST_VAL[g];
          q[g]    <= RST_VAL[g];
        end else begin
          meta[g] <= d[g];
          q[g]    <= meta[g];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/ctlword_shift.sv
module ctlword_shift #(
  parameter int unsigned        WORD_W    = 24,
  parameter int unsigned        CW        = 5,
  parameter logic [WORD_W-1:0]  SAFE_WORD = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic              cs_n_s,
  input  logic              cnt_clr,
  input  logic [WORD_W-1:0] word_q,
  output logic [WORD_W-1:0] shreg,
  output logic [CW-1:0]     cnt,
  output logic              miso
);

  localparam logic [CW-1:0] CNT_MAX = CW'(WORD_W + 1);

  logic              sclk_d;
  logic              cs_n_d;
  logic              sclk_rise;
  logic              sclk_fall;
  logic              cs_start;
  logic              cs_idle;
  logic [WORD_W-1:0] tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_n_d <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_n_d <= cs_n_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_start  = ~cs_n_s & cs_n_d;
  assign cs_idle   = cs_n_s;

  // Incoming word, MSB first.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
    end else if (!cs_idle && sclk_rise) begin
      shreg <= {shreg[WORD_W-2:0], mosi_s};
    end
  end

  // Bit count of the current window; saturates at WORD_W+1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cs_start || cnt_clr) begin
      cnt <= '0;
    end else if (!cs_idle && sclk_rise && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  // Read-back: snapshot of the applied word, shifted out on falling edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx <= SAFE_WORD;
    end else if (cs_start) begin
      tx <= word_q;
    end else if (!cs_idle && sclk_fall) begin
      tx <= {tx[WORD_W-2:0], 1'b0};
    end
  end

  assign miso = tx[WORD_W-1];

  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> $stable(shreg)); // R5

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_MAX); // R7

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_s && cs_n_d) |=> cnt == '0); // R10

endmodule

// File: rtl/ctlword_latch.sv
module ctlword_latch #(
  parameter int unsigned        WORD_W    = 24,
  parameter int unsigned        CW        = 5,
  parameter logic [WORD_W-1:0]  SAFE_WORD = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              le_s,
  input  logic [CW-1:0]     cnt,
  input  logic [WORD_W-1:0] shreg,
  output logic [WORD_W-1:0] word_q,
  output logic              err,
  output logic              accept
);

  logic le_d;
  logic le_rise;
  logic len_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) le_d <= 1'b0;
    else        le_d <= le_s;
  end

  assign le_rise = le_s & ~le_d;
  assign len_ok  = (cnt == CW'(WORD_W));
  assign accept  = le_rise & len_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= SAFE_WORD;
    end else if (accept) begin
      word_q <= shreg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err <= 1'b0;
    end else if (le_rise && !len_ok) begin
      err <= 1'b1;
    end
  end

  AST_CHANGE_NEEDS_LE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_q) |-> $past(le_rise)); // R3

  AST_BAD_LEN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && !len_ok) |=> ($stable(word_q) && err)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R8

endmodule

// File: rtl/ctlword_rx.sv
module ctlword_rx
  import ctlword_rx_pkg::*;
#(
  parameter int unsigned        WORD_W    = 24,
  parameter logic [WORD_W-1:0]  SAFE_WORD = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              cs_n_i,
  input  logic              le_i,
  output logic [WORD_W-1:0] word_o,
  output logic              miso_o,
  output logic              len_err_o
);

  localparam int unsigned CW = cnt_width(WORD_W);
  localparam int unsigned LW = $bits(link_t);

  link_t             link_raw;
  link_t             link_s;
  logic [WORD_W-1:0] shreg;
  logic [CW-1:0]     cnt;
  logic              accept;

  assign link_raw = '{sclk: sclk_i, mosi: mosi_i, cs_n: cs_n_i, le: le_i};

  ctlword_sync #(
    .N       (LW),
    .RST_VAL (LINK_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (link_raw),
    .q     (link_s)
  );

  ctlword_shift #(
    .WORD_W    (WORD_W),
    .CW        (CW),
    .SAFE_WORD (SAFE_WORD)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s  (link_s.sclk),
    .mosi_s  (link_s.mosi),
    .cs_n_s  (link_s.cs_n),
    .cnt_clr (accept),
    .word_q  (word_o),
    .shreg   (shreg),
    .cnt     (cnt),
    .miso    (miso_o)
  );

  ctlword_latch #(
    .WORD_W    (WORD_W),
    .CW        (CW),
    .SAFE_WORD (SAFE_WORD)
  ) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .le_s   (link_s.le),
    .cnt    (cnt),
    .shreg  (shreg),
    .word_q (word_o),
    .err    (len_err_o),
    .accept (accept)
  );

  AST_WHOLE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_o) |-> word_o == $past(shreg)); // R4

endmodule

// File: tb/ctlword_rx_bench.sv
module ctlword_rx_bench;

  localparam int unsigned W    = 24;
  localparam logic [W-1:0] SAFE = '1;
  localparam int HALF = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sclk_i = 1'b0;
  logic         mosi_i = 1'b0;
  logic         cs_n_i = 1'b1;
  logic         le_i = 1'b0;
  logic [W-1:0] word_o;
  logic         miso_o;
  logic         len_err_o;

  int tests = 0;
  int fails = 0;
  int glitches = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_word = SAFE;
  logic [W-1:0] exp_pend = SAFE;

  always #10 clk = ~clk;

  ctlword_rx #(.WORD_W(W), .SAFE_WORD(SAFE)) u_ctlword_rx (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .mosi_i(mosi_i),
    .cs_n_i(cs_n_i), .le_i(le_i), .word_o(word_o), .miso_o(miso_o),
    .len_err_o(len_err_o)
  );

  // R4 monitor: only the old or the new expected word may be seen.
  always @(negedge clk) begin
    if (rst_n && word_o !== exp_word && word_o !== exp_pend) glitches++;
  end

  function automatic logic [W-1:0] next_word(input logic [W-1:0] prev,
                                             input logic [W-1:0] shifted,
                                             input int nbits);
    return (nbits == W) ? shifted : prev;
  endfunction

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    exp_word = SAFE;
    exp_pend = SAFE;
    w(3);
    rst_n = 1'b1;
    w(3);
  endtask

  task automatic send(input logic [63:0] bits, input int n,
                      output logic [W-1:0] rd);
    rd = '0;
    cs_n_i = 1'b0;
    w(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      mosi_i = bits[i];
      w(HALF);
      if (n - 1 - i < int'(W)) rd = {rd[W-2:0], miso_o};
      sclk_i = 1'b1;
      w(HALF);
      sclk_i = 1'b0;
    end
    w(HALF);
    cs_n_i = 1'b1;
    w(HALF);
  endtask

  task automatic latch(input logic [W-1:0] nxt);
    exp_pend = nxt;
    le_i = 1'b1;
    w(4);
    le_i = 1'b0;
    w(HALF);
    exp_word = nxt;
  endtask

  task automatic full_write(input logic [W-1:0] val, input string req);
    logic [W-1:0] rd;
    logic [W-1:0] prev;
    prev = exp_word;
    send({40'd0, val}, W, rd);
    check(rd == prev, "R9 read-back", rd, prev);
    check(word_o == prev, "R3 hold before latch", word_o, prev);
    latch(next_word(prev, val, W));
    check(word_o == val, req, word_o, val);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] rd;
    logic [W-1:0] v;
    logic [W-1:0] prev;
    void'($urandom(32'd2718));
    do_reset();
    check(word_o == SAFE, "R1 reset word", word_o, SAFE);
    check(len_err_o == 1'b0, "R1 reset err", len_err_o, 0);
    check(miso_o == SAFE[W-1], "R1 reset miso", miso_o, SAFE[W-1]);

    // R2 / R4: step code 15 then 16, watched every cycle.
    full_write(24'd15, "R2 word 15");
    full_write(24'd16, "R2 word 16");
    full_write(24'hA5C3E1, "R2 mixed pattern");

    // R5: clock edges with chip-select high must not disturb the word.
    v = 24'h3C0F96;
    send({40'd0, v}, W, rd);
    for (int k = 0; k < 5; k++) begin
      mosi_i = k[0];
      w(HALF); sclk_i = 1'b1; w(HALF); sclk_i = 1'b0;
    end
    latch(v);
    check(word_o == v, "R5 idle clocks ignored", word_o, v);
    check(len_err_o == 1'b0, "R5 no error", len_err_o, 0);

    // R6: one bit short.
    prev = exp_word;
    send(64'h12345, W - 1, rd);
    latch(next_word(prev, 24'h012345, W - 1));
    check(word_o == prev, "R6 short word ignored", word_o, prev);
    check(len_err_o == 1'b1, "R6 error set", len_err_o, 1);

    // R8: a later valid latch leaves the error set.
    full_write(24'h00FF00, "R8 valid after error");
    check(len_err_o == 1'b1, "R8 error sticky", len_err_o, 1);

    do_reset();
    check(word_o == SAFE, "R1 second reset word", word_o, SAFE);
    check(len_err_o == 1'b0, "R1 second reset err", len_err_o, 0);

    // R7: one bit long.
    send(64'h1ABCDEF, W + 1, rd);
    latch(SAFE);
    check(word_o == SAFE, "R7 long word ignored", word_o, SAFE);
    check(len_err_o == 1'b1, "R7 error set", len_err_o, 1);

    do_reset();
    // R10: aborted partial write, then a full one.
    send(64'h15, 5, rd);
    full_write(24'h5A5A5A, "R10 full after aborted");
    check(len_err_o == 1'b0, "R10 no error", len_err_o, 0);

    for (int k = 0; k < 20; k++) begin
      v = W'($urandom);
      full_write(v, "R2 random word");
    end
    check(len_err_o == 1'b0, "R6 no error on exact lengths", len_err_o, 0);
    check(glitches == 0, "R4 no intermediate word", glitches, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule